// File: doc/BRIEF.md
# Configurable UART Frame Transceiver

This block is a full-duplex asynchronous serial port whose character format is chosen at run time. A companion baud generator supplies a single-cycle tick at sixteen times the bit rate; the transmitter and the receiver each count sixteen ticks per bit. Bytes written on the data port are queued in a transmit FIFO and shifted out on `txd`. Characters assembled from the serial input are queued in a receive FIFO, and the oldest one is always presented on `rd_data`.

A 7-bit line control input selects the word length (5 to 8 bits), parity (off, even or odd), one or two stop bits, whether the FIFOs are used, and a forced break that holds `txd` low. Framing, parity, break and overrun events accumulate in a sticky 4-bit status that any write on `stat_clr` empties. A loopback enable routes the transmitter output straight into the receiver, so the whole path can be exercised without external wiring. The FIFO flags and a busy flag are exported for the surrounding interrupt and driver logic.

Top module: `uart_frame_xcvr`

## Requirements
- R1: After reset, `stat` is 0, both FIFOs are empty (`rx_empty`=1, `tx_empty`=1, `rx_full`=0, `tx_full`=0), `busy` is 0 and `txd` idles high.
- R2: A transmitted character is one low start bit, then the data bits least significant first, then the stop bit(s) high; each bit lasts 16 ticks. `line_ctl[6:5]` sets the word length: 00 five, 01 six, 10 seven, 11 eight bits. Received characters shorter than 8 bits are zero-extended on `rd_data`.
- R3: `line_ctl[1]`=1 inserts a parity bit after the data; `line_ctl[2]`=1 makes it even parity and 0 odd parity, computed over the configured data bits only. A received parity mismatch sets `stat[1]`.
- R4: `line_ctl[3]`=1 sends two stop bits, 0 sends one. The receiver checks the first stop position; a low stop bit on a character that is not a break sets `stat[0]` (framing error) and the character is still stored.
- R5: `line_ctl[0]`=1 drives `txd` low regardless of the transmitter. When the receiver sees low for the whole frame including the stop position, it stores exactly one character 0x00 and sets `stat[2]` without setting `stat[0]` or `stat[1]`, then waits for the line to return high.
- R6: A character completed while the receive FIFO is full is discarded and sets `stat[3]`; the stored characters are unchanged.
- R7: With `line_ctl[4]`=1 each FIFO holds 16 characters; with `line_ctl[4]`=0 each holds one. `tx_full`, `tx_empty`, `rx_full` and `rx_empty` report that occupancy; characters leave in the order they entered.
- R8: Status bits are sticky. A cycle with `stat_clr`=1 clears all four bits, except that an error event occurring in the same cycle is kept.
- R9: `busy` is 1 from the cycle after a write until the last stop bit of the last queued character has been sent, and is 0 only when the transmit FIFO and the shift register are both empty.
- R10: With `loop_en`=1 the receiver takes its input from the transmitter output, so each written character is received with the configured format and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| line_ctl | input | 7 | Frame format and break control |
| loop_en | input | 1 | Internal loopback from transmitter to receiver |
| wr_en | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | 8 | Character to transmit |
| rd_en | input | 1 | Pop strobe for the receive FIFO |
| rd_data | output | 8 | Oldest received character |
| stat_clr | input | 1 | Clears the sticky status |
| stat | output | 4 | Sticky flags: [0] framing, [1] parity, [2] break, [3] overrun |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_full | output | 1 | Receive FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| busy | output | 1 | Transmitter still has a character to send |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The two functions that can meet in one cycle are a status clear and the completion of a received character carrying an error. The bench holds `stat_clr` high while a frame with a bad parity bit arrives, and releases it in the first cycle where `rx_empty` shows that the character was stored; the parity flag must then read as set, proving that the new event outweighs the clear applied at the same edge. A similar collision between a completed character and a full receive FIFO is provoked in both FIFO modes and judged by the overrun flag and the unchanged stored data.

// File: rtl/uart_xcvr_pkg.sv
`timescale 1ns/1ps
package uart_xcvr_pkg;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_RECOV} rx_state_e;

  // Field layout follows the control word bit positions
  typedef struct packed {
    logic [1:0] wlen;
    logic       fifo_en;
    logic       two_stop;
    logic       par_even;
    logic       par_en;
    logic       brk_force;
  } lcr_t;

  function automatic logic [3:0] word_bits(input logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction

  function automatic logic [7:0] word_mask(input logic [1:0] wl);
    case (wl)
      2'b00:   return 8'h1F;
      2'b01:   return 8'h3F;
      2'b10:   return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic [1:0] wl, input logic even);
    logic p;
    p = ^(d & word_mask(wl));
    return even ? p : ~p;
  endfunction

endpackage

// File: rtl/uart_xcvr_fifo.sv
`timescale 1ns/1ps
module uart_xcvr_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt == $past(cnt))); // R7

endmodule

// File: rtl/uart_xcvr_tx.sv
`timescale 1ns/1ps
module uart_xcvr_tx
  import uart_xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       pop,
  output logic       ser,
  output logic       active
);
  tx_state_e  state;
  logic [3:0] tcnt;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic       pbit;
  logic       second;
  logic       bit_end;

  assign pop     = (state == TX_IDLE) && !fifo_empty;
  assign active  = (state != TX_IDLE);
  assign bit_end = tick && (tcnt == 4'hF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      tcnt   <= '0;
      bcnt   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      second <= 1'b0;
      ser    <= 1'b1;
    end else if (state == TX_IDLE) begin
      if (!fifo_empty) begin
        state <= TX_START;
        tcnt  <= '0;
        sh    <= fifo_data;
        pbit  <= parity_of(fifo_data, wlen, par_even);
        ser   <= 1'b0;
      end
    end else begin
      if (tick) tcnt <= tcnt + 4'd1;
      if (bit_end) begin
        case (state)
          TX_START: begin
            state <= TX_DATA;
            bcnt  <= 4'd1;
            ser   <= sh[0];
          end
          TX_DATA: begin
            if (bcnt == word_bits(wlen)) begin
              if (par_en) begin
                state <= TX_PAR;
                ser   <= pbit;
              end else begin
                state  <= TX_STOP;
                ser    <= 1'b1;
                second <= 1'b0;
              end
            end else begin
              ser  <= sh[bcnt[2:0]];
              bcnt <= bcnt + 4'd1;
            end
          end
          TX_PAR: begin
            state  <= TX_STOP;
            ser    <= 1'b1;
            second <= 1'b0;
          end
          TX_STOP: begin
            if (two_stop && !second) second <= 1'b1;
            else                     state  <= TX_IDLE;
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_START) |-> !ser); // R2
  AST_TX_PAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_PAR) |-> (ser == pbit)); // R3
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_STOP) |-> ser); // R4

endmodule

// File: rtl/uart_xcvr_rx.sv
`timescale 1ns/1ps
module uart_xcvr_rx
  import uart_xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       line,
  output logic       done,
  output logic [7:0] data,
  output logic       fe,
  output logic       pe,
  output logic       brk
);
  rx_state_e  state;
  logic [3:0] tcnt;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic       pbit;
  logic       anyhi;
  logic       samp_mid;

  assign samp_mid = tick && (tcnt == 4'hF);
  assign done     = (state == RX_STOP) && samp_mid;
  assign brk      = !line && !anyhi;
  assign fe       = !line && anyhi;
  assign pe       = par_en && anyhi && (pbit != parity_of(sh, wlen, par_even));
  assign data     = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      anyhi <= 1'b0;
    end else begin
      if (tick && (state == RX_DATA || state == RX_PAR || state == RX_STOP))
        tcnt <= tcnt + 4'd1;
      case (state)
        RX_IDLE: if (tick && !line) begin
          state <= RX_START;
          tcnt  <= '0;
        end
        RX_START: if (tick) begin
          if (tcnt == 4'd6) begin
            if (!line) begin
              state <= RX_DATA;
              tcnt  <= '0;
              bcnt  <= '0;
              sh    <= '0;
              anyhi <= 1'b0;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        RX_DATA: if (samp_mid) begin
          sh[bcnt[2:0]] <= line;
          anyhi         <= anyhi | line;
          if ((bcnt + 4'd1) == word_bits(wlen)) state <= par_en ? RX_PAR : RX_STOP;
          else                                  bcnt  <= bcnt + 4'd1;
        end
        RX_PAR: if (samp_mid) begin
          pbit  <= line;
          anyhi <= anyhi | line;
          state <= RX_STOP;
        end
        RX_STOP: if (samp_mid) state <= line ? RX_IDLE : RX_RECOV;
        RX_RECOV: if (tick && line) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_RX_BRK_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && brk) |-> (data == 8'h00)); // R5
  AST_RX_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((data & ~word_mask(wlen)) == 8'h00)); // R2

endmodule

// File: rtl/uart_frame_xcvr.sv
`timescale 1ns/1ps
module uart_frame_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [6:0] line_ctl,
  input  logic       loop_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       stat_clr,
  output logic [3:0] stat,
  output logic       rx_empty,
  output logic       tx_full,
  output logic       rx_full,
  output logic       tx_empty,
  output logic       busy,
  input  logic       rxd,
  output logic       txd
);
  lcr_t       cfg;
  logic       rxd_s1, rxd_s2, line_in;
  logic       tx_pop, tx_ser, tx_active;
  logic [7:0] tx_head;
  logic       rx_done, rx_fe, rx_pe, rx_brk;
  logic [7:0] rx_char;
  logic       rx_push;
  logic       ev_fe, ev_pe, ev_brk, ev_ovr;
  logic [3:0] stat_q;

  assign cfg     = lcr_t'(line_ctl);
  assign txd     = !cfg.brk_force && tx_ser;
  assign line_in = loop_en ? txd : rxd_s2;
  assign busy    = !tx_empty || tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_s1 <= 1'b1;
      rxd_s2 <= 1'b1;
    end else begin
      rxd_s1 <= rxd;
      rxd_s2 <= rxd_s1;
    end
  end

  uart_xcvr_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .single(!cfg.fifo_en),
    .push(wr_en), .pop(tx_pop), .din(wr_data), .dout(tx_head),
    .empty(tx_empty), .full(tx_full));

  uart_xcvr_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .wlen(cfg.wlen),
    .par_en(cfg.par_en), .par_even(cfg.par_even), .two_stop(cfg.two_stop),
    .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop),
    .ser(tx_ser), .active(tx_active));

  uart_xcvr_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .wlen(cfg.wlen),
    .par_en(cfg.par_en), .par_even(cfg.par_even), .line(line_in),
    .done(rx_done), .data(rx_char), .fe(rx_fe), .pe(rx_pe), .brk(rx_brk));

  assign rx_push = rx_done && !rx_full;
  assign ev_ovr  = rx_done && rx_full;
  assign ev_fe   = rx_push && rx_fe;
  assign ev_pe   = rx_push && rx_pe;
  assign ev_brk  = rx_push && rx_brk;

  uart_xcvr_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .single(!cfg.fifo_en),
    .push(rx_push), .pop(rd_en), .din(rx_char), .dout(rd_data),
    .empty(rx_empty), .full(rx_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_clr ? 4'h0 : stat_q) | {ev_ovr, ev_brk, ev_pe, ev_fe};
  end
  assign stat = stat_q;

  AST_OVR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |=> stat[3]); // R6
  AST_ERR_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pe || ev_fe) |=> (stat[1] || stat[0])); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !rx_done) |=> (stat == 4'h0)); // R8
  AST_BRK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk |-> !(ev_fe || ev_pe)); // R5
  AST_BUSY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tx_empty); // R9
  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_full) |=> busy); // R9

endmodule

// File: tb/tb_uart_frame_xcvr.sv
`timescale 1ns/1ps
module tb_uart_frame_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [6:0] line_ctl = 7'b1110000;
  logic       loop_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       stat_clr = 1'b0;
  logic [3:0] stat;
  logic       rx_empty, tx_full, rx_full, tx_empty, busy;
  logic       rxd = 1'b1;
  logic       txd;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int tdiv = 0;
  localparam int BITCLK = 64;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  uart_frame_xcvr dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_ctl(line_ctl), .loop_en(loop_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .stat_clr(stat_clr), .stat(stat), .rx_empty(rx_empty), .tx_full(tx_full),
    .rx_full(rx_full), .tx_empty(tx_empty), .busy(busy), .rxd(rxd), .txd(txd));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int low_mask(input int nb);
    return (1 << nb) - 1;
  endfunction

  function automatic bit exp_par(input int d, input int nb, input bit even);
    int ones = $countones(d & low_mask(nb));
    return even ? bit'(ones % 2) : bit'((ones + 1) % 2);
  endfunction

  function automatic logic [6:0] mk_ctl(input int nb, input bit pen, input bit even,
                                        input bit two, input bit fen, input bit brk);
    logic [1:0] code = 2'(nb - 5);
    return {code, fen, two, even, pen, brk};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    wr_data = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    b = rd_data; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_rx();
    for (int k = 0; k < 4000 && rx_empty; k++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
  endtask

  task automatic clear_stat();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic ser_send(input int d, input int nb, input bit pen, input bit pbit, input bit stopv);
    rxd = 1'b0; cyc(BITCLK);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; cyc(BITCLK); end
    if (pen) begin rxd = pbit; cyc(BITCLK); end
    rxd = stopv; cyc(BITCLK);
    rxd = 1'b1; cyc(2 * BITCLK);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd7));
    cyc(5);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    chk("R1 stat", stat, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 busy", busy, 0);
    chk("R1 txd idle", txd, 1);

    // R2 R3 R4 R9: waveform of 7 bits, even parity, two stops; bit 7 must not affect parity
    line_ctl = mk_ctl(7, 1, 1, 1, 1, 0);
    put_byte(8'hB5);
    chk("R9 busy after write", busy, 1);
    for (int k = 0; k < 200 && txd; k++) @(negedge clk);
    cyc(BITCLK / 2);
    chk("R2 start bit", txd, 0);
    for (int i = 0; i < 7; i++) begin
      cyc(BITCLK);
      chk($sformatf("R2 data bit %0d lsb first", i), txd, (8'h35 >> i) & 1);
    end
    cyc(BITCLK);
    chk("R3 even parity over 7 bits", txd, exp_par(8'hB5, 7, 1));
    cyc(BITCLK);
    chk("R4 stop 1", txd, 1);
    cyc(BITCLK);
    chk("R4 stop 2", txd, 1);
    chk("R9 busy in second stop", busy, 1);
    wait_idle();
    chk("R9 busy drained", busy, 0);
    chk("R9 tx_empty", tx_empty, 1);

    // R10 R2 R3 R4: random loopback formats
    loop_en = 1'b1;
    for (int t = 0; t < 30; t++) begin
      int nb = 5 + int'($urandom % 4);
      bit pen = 1'($urandom);
      bit ev = 1'($urandom);
      bit two = 1'($urandom);
      logic [7:0] d = 8'($urandom);
      line_ctl = mk_ctl(nb, pen, ev, two, 1, 0);
      put_byte(d);
      wait_rx();
      get_byte(r);
      chk($sformatf("R10 loopback data nb=%0d", nb), r, d & low_mask(nb));
      chk("R10 loopback no error", stat, 0);
      wait_idle();
      chk("R9 idle after frame", busy, 0);
    end
    loop_en = 1'b0;

    // R3 parity error detected
    line_ctl = mk_ctl(8, 1, 1, 0, 1, 0);
    ser_send(8'h5A, 8, 1, !exp_par(8'h5A, 8, 1), 1);
    wait_rx(); get_byte(r);
    chk("R3 data with bad parity", r, 8'h5A);
    chk("R3 parity flag", stat, 4'h2);
    clear_stat();
    chk("R8 clear", stat, 0);

    // R3 odd parity, 6 bits, correct
    line_ctl = mk_ctl(6, 1, 0, 0, 1, 0);
    ser_send(8'h2B, 6, 1, exp_par(8'h2B, 6, 0), 1);
    wait_rx(); get_byte(r);
    chk("R3 odd 6-bit data", r, 8'h2B);
    chk("R3 odd parity no error", stat, 0);

    // R4 framing error
    line_ctl = mk_ctl(8, 0, 0, 0, 1, 0);
    ser_send(8'h33, 8, 0, 0, 0);
    wait_rx(); get_byte(r);
    chk("R4 data kept on framing error", r, 8'h33);
    chk("R4 framing flag", stat, 4'h1);
    clear_stat();

    // R8 error event in the same cycle as clear
    line_ctl = mk_ctl(8, 1, 1, 0, 1, 0);
    fork
      ser_send(8'hC3, 8, 1, !exp_par(8'hC3, 8, 1), 1);
      begin
        stat_clr = 1'b1;
        while (rx_empty) @(negedge clk);
        stat_clr = 1'b0;
      end
    join
    get_byte(r);
    chk("R8 event wins over clear", stat, 4'h2);
    clear_stat();

    // R5 forced break and break detection
    loop_en = 1'b1;
    line_ctl = mk_ctl(8, 0, 0, 0, 1, 1);
    cyc(20 * BITCLK);
    chk("R5 forced break txd", txd, 0);
    line_ctl = mk_ctl(8, 0, 0, 0, 1, 0);
    cyc(4 * BITCLK);
    chk("R5 break stored", rx_empty, 0);
    get_byte(r);
    chk("R5 break char null", r, 0);
    chk("R5 break flag only", stat, 4'h4);
    chk("R5 single break char", rx_empty, 1);
    clear_stat();

    // R6 R7 overrun with single-entry queues
    line_ctl = mk_ctl(8, 0, 0, 0, 0, 0);
    put_byte(8'hA1); cyc(4);
    put_byte(8'h5C); cyc(4);
    wait_idle(); cyc(BITCLK);
    chk("R7 single entry full", rx_full, 1);
    chk("R6 overrun flag", stat, 4'h8);
    get_byte(r);
    chk("R6 first char kept", r, 8'hA1);
    chk("R6 second discarded", rx_empty, 1);
    clear_stat();

    // R7 R6 sixteen-entry queues
    line_ctl = mk_ctl(8, 0, 0, 0, 1, 0);
    for (int i = 0; i < 17; i++) put_byte(8'(8'h10 + i));
    chk("R7 tx_full", tx_full, 1);
    chk("R7 tx not empty", tx_empty, 0);
    wait_idle(); cyc(BITCLK);
    chk("R7 rx_full at 16", rx_full, 1);
    chk("R6 overrun on 17th", stat, 4'h8);
    for (int i = 0; i < 16; i++) begin
      get_byte(r);
      chk($sformatf("R7 order %0d", i), r, 8'h10 + i);
    end
    chk("R7 rx drained", rx_empty, 1);
    clear_stat();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule